// File: doc/BRIEF.md
# Variable-Length Instruction Operand Decoder

This block sits between an instruction byte source and the execute stage of an 8-bit processor that uses 16-bit addresses. Bytes arrive one per valid/ready handshake. The first byte of each instruction is a header. Its upper nibble is the operation code and its lower nibble holds four argument-type bits. The header sets the number of arguments that follow and the width of each one. Each argument is one or two bytes long.

The decoder collects the argument bytes and produces one complete record. The record holds the operation, the argument count, the total instruction length in bytes, and a kind and a value for each of the three argument slots. The length lets a fetch unit advance its program counter. While a record waits for the consumer, no further byte is accepted. A one-cycle done pulse marks the first cycle in which each record is presented.

Top module: `opnd_decoder`

## Requirements
- R1: Header bits 7:4 give the operation code, reported on `out_op`. Bits 3, 2, 1 and 0 are the type bits A, B, C and D.
- R2: Kind codes are register index = 0, memory address = 1, byte literal = 2 and word literal = 3. Kinds 1 and 3 take two bytes and kinds 0 and 2 take one byte. Slot 1 has kind 0 when A=0 and kind 1 when A=1.
- R3: Slot 2 has kind B + 2*C.
- R4: Slot 3 has kind 0 when D=0 and kind 1 when D=1.
- R5: For operation code 1101, slot 1 is always a byte literal (kind 2), whatever the value of A.
- R6: The argument count on `out_nargs` is 0 for code 1111. It is 2 for codes 0000, 1000, 0100, 0010, 1010, 0101 and 0111, and 3 for every other code. An unused slot reports kind 0 and value 0.
- R7: A two-byte argument arrives high byte first and is reported as the 16-bit value {first, second}. A one-byte argument is zero-extended to 16 bits.
- R8: `out_len` equals 1 plus the byte count of every used slot, giving a range of 1 to 7.
- R9: `out_valid` rises in the cycle after the last byte of an instruction is accepted. From then until the cycle after `out_ready` is sampled high, the record holds steady and `in_ready` is low. After that, `in_ready` is high again.
- R10: `done` is high for exactly one cycle, the first cycle of each record.
- R11: A synchronous active-high reset brings `in_ready` high and `out_valid` and `done` low. It also discards any partly received instruction, so the next byte accepted is treated as a header.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input byte is valid |
| in_byte | input | 8 | Instruction stream byte |
| in_ready | output | 1 | Decoder accepts a byte this cycle |
| out_valid | output | 1 | Decoded record is presented |
| out_ready | input | 1 | Consumer takes the record |
| done | output | 1 | One-cycle pulse on the first cycle of a record |
| out_op | output | 4 | Operation code |
| out_nargs | output | 2 | Argument count |
| out_len | output | 3 | Instruction length in bytes |
| out_kinds | output | 6 | Slot kinds, slot 1 in bits 1:0 |
| out_vals | output | 48 | Slot values, slot 1 in bits 15:0 |

## Verification
The stream mixes headers that cover each slot-2 type, both values of A and D, all three arities, and the 1101 code with A set. This separates a slot-kind mistake from an arity mistake and a length mistake. The stream runs twice. The first pass has no gaps and the consumer is always ready, which exposes any off-by-one in the cycle timing. The second pass uses random input gaps and random consumer stalls, which exposes records that change or bytes that are taken during a stall. A reset in the middle of an instruction, followed by new instructions, shows whether stale half-collected state leaks into the next record.

// File: rtl/opnd_dec_pkg.sv
package opnd_dec_pkg;

    localparam int BYTE_W = 8;
    localparam int WORD_W = 2 * BYTE_W;
    localparam int NSLOT  = 3;
    localparam int KIND_W = 2;
    localparam int LEN_W  = 3;
    localparam int CNT_W  = 2;

    typedef enum logic [3:0] {
        OP_COPY  = 4'b0000, OP_ADVW = 4'b1000, OP_INV   = 4'b0100, OP_ANDB = 4'b1100,
        OP_INCR  = 4'b0010, OP_DECR = 4'b1010, OP_SUM   = 4'b0110, OP_DIFF = 4'b1110,
        OP_BRZ   = 4'b0001, OP_BRNZ = 4'b1001, OP_GOTO  = 4'b0101, OP_STLIT = 4'b1101,
        OP_STREG = 4'b0011, OP_LOAD = 4'b1011, OP_CALL  = 4'b0111, OP_RET  = 4'b1111
    } op_e;

    typedef enum logic [KIND_W-1:0] {
        K_REG   = 2'd0,
        K_MEM   = 2'd1,
        K_LIT8  = 2'd2,
        K_LIT16 = 2'd3
    } kind_e;

    typedef enum logic [1:0] {
        ST_HDR,
        ST_ARG,
        ST_OUT
    } state_e;

    function automatic logic [CNT_W-1:0] op_arity(input logic [3:0] op);
        case (op)
            OP_RET:                                  return 2'd0;
            OP_COPY, OP_ADVW, OP_INV, OP_INCR,
            OP_DECR, OP_GOTO, OP_CALL:               return 2'd2;
            default:                                 return 2'd3;
        endcase
    endfunction

    function automatic logic [KIND_W-1:0] slot_kind(input int s, input logic [BYTE_W-1:0] hdr);
        case (s)
            0: begin
                if (hdr[7:4] == OP_STLIT) return K_LIT8;
                return hdr[3] ? K_MEM : K_REG;
            end
            1:       return {hdr[1], hdr[2]};
            default: return hdr[0] ? K_MEM : K_REG;
        endcase
    endfunction

    function automatic logic is_wide(input logic [KIND_W-1:0] k);
        return (k == K_MEM) || (k == K_LIT16);
    endfunction

endpackage

// File: rtl/opnd_hdr_decode.sv
module opnd_hdr_decode
    import opnd_dec_pkg::*;
(
    input  logic [BYTE_W-1:0]             hdr,
    output logic [3:0]                    op,
    output logic [NSLOT-1:0][KIND_W-1:0]  kinds,
    output logic [CNT_W-1:0]              nargs,
    output logic [LEN_W-1:0]              len
);

    always_comb begin
        op    = hdr[7:4];
        nargs = op_arity(hdr[7:4]);
        len   = LEN_W'(1);
        for (int s = 0; s < NSLOT; s++) begin
            if (CNT_W'(s) < nargs) begin
                kinds[s] = slot_kind(s, hdr);
                len      = len + (is_wide(kinds[s]) ? LEN_W'(2) : LEN_W'(1));
            end else begin
                kinds[s] = K_REG;
            end
        end
    end

endmodule

// File: rtl/opnd_arg_gather.sv
module opnd_arg_gather
    import opnd_dec_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          start,
    input  logic                          take,
    input  logic [BYTE_W-1:0]             in_byte,
    input  logic [NSLOT-1:0][KIND_W-1:0]  kinds,
    input  logic [CNT_W-1:0]              nargs,
    output logic [NSLOT-1:0][WORD_W-1:0]  vals,
    output logic                          last
);

    logic [CNT_W-1:0] slot;
    logic             half;
    logic             cur_wide;

    assign cur_wide = is_wide(kinds[slot]);
    assign last     = take && (!cur_wide || half) && (slot == nargs - CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst || start) begin
            slot <= '0;
            half <= 1'b0;
            vals <= '0;
        end else if (take) begin
            if (cur_wide && !half) begin
                vals[slot][WORD_W-1:BYTE_W] <= in_byte;
                half                        <= 1'b1;
            end else begin
                if (cur_wide)
                    vals[slot][BYTE_W-1:0] <= in_byte;
                else
                    vals[slot] <= {{(WORD_W-BYTE_W){1'b0}}, in_byte};
                half <= 1'b0;
                slot <= slot + CNT_W'(1);
            end
        end
    end

    // R6: bytes are only gathered for slots the operation actually uses
    a_r6_slot_in_use: assert property (@(posedge clk) disable iff (rst)
        take |-> (slot < nargs));

    // R7: a pending high byte only exists for a two-byte slot
    a_r7_half_wide: assert property (@(posedge clk) disable iff (rst)
        half |-> cur_wide);

endmodule

// File: rtl/opnd_decoder.sv
module opnd_decoder
    import opnd_dec_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    input  logic [BYTE_W-1:0]        in_byte,
    output logic                     in_ready,
    output logic                     out_valid,
    input  logic                     out_ready,
    output logic                     done,
    output logic [3:0]               out_op,
    output logic [CNT_W-1:0]         out_nargs,
    output logic [LEN_W-1:0]         out_len,
    output logic [NSLOT*KIND_W-1:0]  out_kinds,
    output logic [NSLOT*WORD_W-1:0]  out_vals
);

    state_e                          state;
    logic                            done_q;
    logic [3:0]                      op_q, dec_op;
    logic [NSLOT-1:0][KIND_W-1:0]    kinds_q, dec_kinds;
    logic [CNT_W-1:0]                nargs_q, dec_nargs;
    logic [LEN_W-1:0]                len_q, dec_len;
    logic [NSLOT-1:0][WORD_W-1:0]    vals;
    logic                            hdr_take, arg_take, last_byte;

    assign hdr_take = (state == ST_HDR) && in_valid;
    assign arg_take = (state == ST_ARG) && in_valid;

    opnd_hdr_decode u_hdr (
        .hdr   (in_byte),
        .op    (dec_op),
        .kinds (dec_kinds),
        .nargs (dec_nargs),
        .len   (dec_len)
    );

    opnd_arg_gather u_gather (
        .clk     (clk),
        .rst     (rst),
        .start   (hdr_take),
        .take    (arg_take),
        .in_byte (in_byte),
        .kinds   (kinds_q),
        .nargs   (nargs_q),
        .vals    (vals),
        .last    (last_byte)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_HDR;
            done_q  <= 1'b0;
            op_q    <= '0;
            kinds_q <= '0;
            nargs_q <= '0;
            len_q   <= '0;
        end else begin
            done_q <= 1'b0;
            case (state)
                ST_HDR: if (in_valid) begin
                    op_q    <= dec_op;
                    kinds_q <= dec_kinds;
                    nargs_q <= dec_nargs;
                    len_q   <= dec_len;
                    if (dec_nargs == '0) begin
                        state  <= ST_OUT;
                        done_q <= 1'b1;
                    end else begin
                        state <= ST_ARG;
                    end
                end
                ST_ARG: if (last_byte) begin
                    state  <= ST_OUT;
                    done_q <= 1'b1;
                end
                ST_OUT: if (out_ready) state <= ST_HDR;
                default: state <= ST_HDR;
            endcase
        end
    end

    assign in_ready  = (state != ST_OUT);
    assign out_valid = (state == ST_OUT);
    assign done      = done_q;
    assign out_op    = op_q;
    assign out_nargs = nargs_q;
    assign out_len   = len_q;

    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        assign out_kinds[g*KIND_W +: KIND_W] = kinds_q[g];
        assign out_vals[g*WORD_W +: WORD_W]  = vals[g];
    end

    // R9: a stalled record does not change
    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_vals) && $stable(out_op)
                                       && $stable(out_len) && $stable(out_kinds)));

    // R10: done only on the first cycle of a record
    a_r10_done_first: assert property (@(posedge clk) disable iff (rst)
        done |-> (out_valid && !$past(out_valid)));

    // R8: length stays inside the encodable range
    a_r8_len_range: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_len >= LEN_W'(1) && out_len <= LEN_W'(7)));

    // R6: the return code is a single byte
    a_r6_ret_short: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_op == OP_RET) |-> (out_len == LEN_W'(1) && out_nargs == '0));

    // R11: the cycle after reset shows no record
    a_r11_reset_idle: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!out_valid && !done && in_ready));

endmodule

// File: tb/sim_opnd_decoder.sv
module sim_opnd_decoder;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [7:0]  in_byte = 8'h00;
    logic        in_ready, out_valid, done;
    logic        out_ready = 1'b1;
    logic [3:0]  out_op;
    logic [1:0]  out_nargs;
    logic [2:0]  out_len;
    logic [5:0]  out_kinds;
    logic [47:0] out_vals;

    int checks = 0;
    int failures = 0;
    int rdy_mode = 0;
    bit started = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    opnd_decoder u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte),
        .in_ready(in_ready), .out_valid(out_valid), .out_ready(out_ready),
        .done(done), .out_op(out_op), .out_nargs(out_nargs), .out_len(out_len),
        .out_kinds(out_kinds), .out_vals(out_vals)
    );

    // ---------------- behavioural reference ----------------
    function automatic int ref_arity(input logic [3:0] op);
        if (op == 4'hF) return 0;
        if (op == 4'h0 || op == 4'h8 || op == 4'h4 || op == 4'h2 ||
            op == 4'hA || op == 4'h5 || op == 4'h7) return 2;
        return 3;
    endfunction

    function automatic int ref_kind(input int s, input logic [7:0] h);
        if (s == 0) return (h[7:4] == 4'hD) ? 2 : int'(h[3]);
        if (s == 1) return int'(h[2]) + 2 * int'(h[1]);
        return int'(h[0]);
    endfunction

    function automatic int ref_len(input logic [7:0] h);
        int n = 1;
        for (int s = 0; s < ref_arity(h[7:4]); s++)
            n += (ref_kind(s, h) % 2 == 1) ? 2 : 1;
        return n;
    endfunction

    logic [7:0] m_buf[$];
    int  m_cnt = 0, m_need = 0;
    bit  m_out = 0, m_done = 0;
    int  e_op, e_n, e_len;
    int  e_kind[3];
    int  e_val[3];

    always @(posedge clk) begin
        started <= 1'b1;
        if (rst) begin
            m_out = 0; m_done = 0; m_cnt = 0; m_buf.delete();
        end else begin
            m_done = 0;
            if (m_out) begin
                if (out_ready) begin m_out = 0; m_cnt = 0; end
            end else if (in_valid) begin
                m_buf.push_back(in_byte);
                if (m_cnt == 0) m_need = ref_len(in_byte);
                m_cnt++;
                if (m_cnt == m_need) begin
                    int p;
                    e_op = int'(m_buf[0][7:4]);
                    e_n = ref_arity(m_buf[0][7:4]);
                    e_len = m_need;
                    p = 1;
                    for (int s = 0; s < 3; s++) begin
                        e_kind[s] = 0; e_val[s] = 0;
                        if (s < e_n) begin
                            e_kind[s] = ref_kind(s, m_buf[0]);
                            if (e_kind[s] % 2 == 1) begin
                                e_val[s] = int'(m_buf[p]) * 256 + int'(m_buf[p+1]);
                                p += 2;
                            end else begin
                                e_val[s] = int'(m_buf[p]);
                                p += 1;
                            end
                        end
                    end
                    m_buf.delete();
                    m_out = 1; m_done = 1;
                end
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s at %0t: actual=%0h expected=%0h", tag, $time, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (started && !finished) begin
            if (rst) begin
                chk("R11 in_ready in reset", int'(in_ready), 1);
                chk("R11 out_valid in reset", int'(out_valid), 0);
            end else begin
                chk("R9 in_ready", int'(in_ready), int'(!m_out));
                chk("R9 out_valid", int'(out_valid), int'(m_out));
                chk("R10 done", int'(done), int'(m_done));
                if (m_out) begin
                    chk("R1 op", int'(out_op), e_op);
                    chk("R6 nargs", int'(out_nargs), e_n);
                    chk("R8 len", int'(out_len), e_len);
                    chk(e_op == 13 ? "R5 slot1 kind" : "R2 slot1 kind", int'(out_kinds[1:0]), e_kind[0]);
                    chk("R3 slot2 kind", int'(out_kinds[3:2]), e_kind[1]);
                    chk("R4 slot3 kind", int'(out_kinds[5:4]), e_kind[2]);
                    chk("R7 slot1 value", int'(out_vals[15:0]), e_val[0]);
                    chk("R7 slot2 value", int'(out_vals[31:16]), e_val[1]);
                    chk("R7 slot3 value", int'(out_vals[47:32]), e_val[2]);
                end
            end
        end
    end

    // consumer: always ready in mode 0, random stalls otherwise
    always @(negedge clk) begin
        if (rdy_mode == 0) out_ready <= 1'b1;
        else               out_ready <= ($urandom_range(0, 2) == 0);
    end

    // ---------------- stimulus ----------------
    task automatic push_byte(input logic [7:0] b, input bit gaps);
        bit ack;
        if (gaps) begin
            int g = $urandom_range(0, 2);
            for (int i = 0; i < g; i++) begin
                in_valid = 1'b0;
                @(negedge clk);
            end
        end
        in_valid = 1'b1;
        in_byte  = b;
        forever begin
            ack = in_ready;
            @(negedge clk);
            if (ack) break;
        end
        in_valid = 1'b0;
    endtask

    logic [7:0] stream[$] = '{
        8'hF0, 8'hFF,
        8'h00, 8'h11, 8'h22,
        8'h0E, 8'h12, 8'h34, 8'hAB, 8'hCD,
        8'h4C, 8'h01, 8'h02, 8'h03, 8'h04,
        8'h63, 8'h05, 8'h7F, 8'h80, 8'h01,
        8'hCF, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66,
        8'hDA, 8'h99, 8'h42, 8'h07,
        8'hD7, 8'h10, 8'hBE, 8'hEF, 8'hC0, 8'hDE,
        8'h58, 8'h12, 8'h34, 8'h09,
        8'hE0, 8'h01, 8'h02, 8'h03,
        8'hB1, 8'h0A, 8'h0B, 8'hFE, 8'hED,
        8'h74, 8'h3C, 8'h56, 8'h78
    };

    task automatic drain();
        for (int i = 0; i < 20; i++) @(negedge clk);
    endtask

    initial begin
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // pass 1: back-to-back, consumer always ready (R1-R10)
        rdy_mode = 0;
        foreach (stream[i]) push_byte(stream[i], 1'b0);
        drain();
        // pass 2: input gaps and consumer stalls (R9, R10)
        rdy_mode = 1;
        foreach (stream[i]) push_byte(stream[i], 1'b1);
        drain();
        // R11: reset in the middle of a seven-byte instruction
        rdy_mode = 0;
        push_byte(8'hCF, 1'b0);
        push_byte(8'h11, 1'b0);
        push_byte(8'h22, 1'b0);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        push_byte(8'hF3, 1'b0);
        push_byte(8'h06, 1'b0);
        push_byte(8'hA5, 1'b0);
        push_byte(8'h5A, 1'b0);
        drain();
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        finished = 1;
        checks++;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule